// File: doc/BRIEF.md
# PLL Bring-up and Idle Sequencer

This block brings a PHY clock PLL up and later puts it to sleep. It does all of this through the PLL's control registers, acting as a master on a small local register bus. When it gets a start request, it first wakes the PLL if the PLL is asleep. It then checks whether the PLL already reports lock. If it does not, the block looks up the divider settings for the reference-clock code it was given. It writes each divider field with its own read-modify-write, strobes the go register, and polls for lock within a bounded number of cycles. When it gets a stop request, it sets the PLL's sleep bit and waits until both power-down indications are up. A profile pin selects which divider table to use. In the alternate profile, a stop request must leave the PLL running.

Every request ends with a one-cycle `done_o` pulse that carries a 2-bit result code. `busy_o` is high for the whole sequence. Requests that arrive while `busy_o` is high are dropped, not queued.

The register bus request channel is valid/ready. Once `bus_req_valid_o` is raised, the request stays up with its address, write flag and write data unchanged until a cycle in which `bus_req_ready_i` is high. Only that cycle counts as the transfer. Only one request is ever outstanding. After a transfer, the block waits for `bus_rsp_valid_i` and only then raises the next request. It is always ready for a response, so the response channel has no back-pressure. For reads, `bus_rsp_rdata_i` is taken in the response cycle.

Top module: `pll_bringup_seq`

## Requirements
- R1: Out of reset and whenever `busy_o` is low, the block drives `busy_o`, `done_o` and `bus_req_valid_o` low.
- R2: On start, the block reads the control word at 0x10. If bit 0 (sleep) is set, it writes the word back with only bit 0 cleared. It then polls the status word at 0x04 until bit 1 (lock) is set. If the timeout expires first, it ends with code 2.
- R3: If status bit 1 reads as set after the wake step, the block ends with code 0 and makes no divider write.
- R4: Frequency codes 0 to 5 stand for 12, 16.8, 19.2, 20, 26 and 38.4 MHz. In profile 0, the (M, N, SD, fractional) values for those codes are (1250,5,20,0), (3125,20,20,0), (1172,8,20,65537), (1000,7,10,0), (1250,12,20,0) and (3125,47,20,92843). Profile 1 uses N=7, SD=6 and fractional 0, with M of 1000, 714, 625, 600, 461 and 312 in the same code order. The DCO range select is always 4.
- R5: The block writes the divider fields in a fixed order, each with a read-modify-write that keeps every other bit of the word. The order is: N into bits 8:1 of 0x0C; DCO range into bits 3:1 of 0x10; M into bits 20:9 of 0x0C; fractional M into bits 17:0 of 0x20; SD into bits 17:10 of 0x14.
- R6: After the SD write, the block writes the value 1 to 0x08. It then polls status bit 1 and ends with code 0 when lock appears.
- R7: If lock has not appeared within TIMEOUT_CYCLES cycles after a poll wait starts, the block ends with code 2 at the first poll response after that limit.
- R8: Frequency codes 6 and above end the sequence with code 1 before any divider-field or go write.
- R9: In profile 0, a stop request sets bit 0 of 0x10 (read-modify-write). It then polls 0x04 until bits 15 and 16 are both set, and ends with code 0.
- R10: If the two power-down bits are not both set within TIMEOUT_CYCLES, a stop request ends with code 3.
- R11: In profile 1, a stop request ends with code 0 and makes no bus request at all.
- R12: While `busy_o` is high, start and stop requests have no effect: each sequence yields exactly one `done_o` and no extra bus traffic.
- R13: A pending bus request keeps valid, address, write flag and data stable until ready is sampled high.
- R14: `done_o` is high for exactly one cycle, the last cycle of `busy_o`, with `err_code_o` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_req_i | input | 1 | Start (bring-up) request, sampled while idle |
| exit_req_i | input | 1 | Stop (sleep) request, sampled while idle; start wins if both are high |
| profile_i | input | 1 | Table/profile select, latched with a request |
| freq_code_i | input | CODE_W | Reference-clock frequency code, latched with a start request |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_code_o | output | 2 | 0 ok, 1 no table entry, 2 lock timeout, 3 power-down timeout |
| bus_req_valid_o | output | 1 | Register request valid |
| bus_req_ready_i | input | 1 | Register slave accepts request |
| bus_req_we_o | output | 1 | Request is a write |
| bus_req_addr_o | output | 8 | Register byte offset |
| bus_req_wdata_o | output | 32 | Write data |
| bus_rsp_valid_i | input | 1 | Response (read data or write acknowledge) |
| bus_rsp_rdata_i | input | 32 | Read data |

## Verification
A wrong step index or a stale read buffer shows up at the bus as a write to the wrong offset, or as a write that disturbs bits outside the target field. The slave model catches this on the very transfer where it happens, because it compares every write against the expected list. A timer that never clears, or never expires, changes the cycle on which `done_o` appears relative to the go write, and it can also change the result code. That shows up within one poll period of the timeout limit. A sequencer that does not return to idle correctly shows up as a missing or doubled `done_o`, or as bus traffic while `busy_o` is low. The per-cycle monitor flags both on the next clock.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned NUM_FREQ  = 6;
  localparam int unsigned NUM_STEPS = 5;
  localparam int unsigned STEP_W    = $clog2(NUM_STEPS);

  localparam logic [ADDR_W-1:0] ADDR_STAT = 8'h04;
  localparam logic [ADDR_W-1:0] ADDR_GO   = 8'h08;
  localparam logic [ADDR_W-1:0] ADDR_CFG1 = 8'h0C;
  localparam logic [ADDR_W-1:0] ADDR_CFG2 = 8'h10;
  localparam logic [ADDR_W-1:0] ADDR_CFG3 = 8'h14;
  localparam logic [ADDR_W-1:0] ADDR_CFG4 = 8'h20;

  localparam int unsigned STAT_LOCK_BIT = 1;
  localparam int unsigned STAT_PDA_BIT  = 15;
  localparam int unsigned STAT_PDB_BIT  = 16;
  localparam int unsigned CFG2_IDLE_BIT = 0;

  typedef struct packed {
    logic [11:0] m;
    logic [7:0]  n;
    logic [2:0]  dco;
    logic [7:0]  sd;
    logic [17:0] frac;
  } div_set_t;

  typedef enum logic [1:0] {
    ERR_NONE     = 2'd0,
    ERR_NO_ENTRY = 2'd1,
    ERR_LOCK_TMO = 2'd2,
    ERR_PD_TMO   = 2'd3
  } err_e;

  function automatic div_set_t div_lookup(input logic alt, input int unsigned idx);
    div_set_t d;
    d = '0;
    d.dco = 3'd4;
    if (alt) begin
      d.n  = 8'd7;
      d.sd = 8'd6;
      case (idx)
        0:       d.m = 12'd1000;
        1:       d.m = 12'd714;
        2:       d.m = 12'd625;
        3:       d.m = 12'd600;
        4:       d.m = 12'd461;
        default: d.m = 12'd312;
      endcase
    end else begin
      case (idx)
        0: begin d.m = 12'd1250; d.n = 8'd5;  d.sd = 8'd20; end
        1: begin d.m = 12'd3125; d.n = 8'd20; d.sd = 8'd20; end
        2: begin d.m = 12'd1172; d.n = 8'd8;  d.sd = 8'd20; d.frac = 18'd65537; end
        3: begin d.m = 12'd1000; d.n = 8'd7;  d.sd = 8'd10; end
        4: begin d.m = 12'd1250; d.n = 8'd12; d.sd = 8'd20; end
        default: begin d.m = 12'd3125; d.n = 8'd47; d.sd = 8'd20; d.frac = 18'd92843; end
      endcase
    end
    return d;
  endfunction

  // Programming order: N, DCO range, M, fractional M, SD.
  function automatic logic [ADDR_W-1:0] step_addr(input logic [STEP_W-1:0] s);
    case (s)
      3'd0:    return ADDR_CFG1;
      3'd1:    return ADDR_CFG2;
      3'd2:    return ADDR_CFG1;
      3'd3:    return ADDR_CFG4;
      default: return ADDR_CFG3;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] step_mask(input logic [STEP_W-1:0] s);
    case (s)
      3'd0:    return 32'h0000_01FE;
      3'd1:    return 32'h0000_000E;
      3'd2:    return 32'h001F_FE00;
      3'd3:    return 32'h0003_FFFF;
      default: return 32'h0003_FC00;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] step_value(input logic [STEP_W-1:0] s, input div_set_t d);
    case (s)
      3'd0:    return {23'b0, d.n, 1'b0};
      3'd1:    return {28'b0, d.dco, 1'b0};
      3'd2:    return {11'b0, d.m, 9'b0};
      3'd3:    return {14'b0, d.frac};
      default: return {14'b0, d.sd, 10'b0};
    endcase
  endfunction

endpackage

// File: rtl/pll_div_table.sv
module pll_div_table
  import pll_seq_pkg::*;
#(
  parameter int unsigned CODE_W = 3
) (
  input  logic              alt_i,
  input  logic [CODE_W-1:0] code_i,
  output div_set_t          set_o,
  output logic              hit_o
);

  localparam int unsigned NUM_PROF = 2;

  div_set_t    prof_set [NUM_PROF];
  int unsigned code_idx;

  assign code_idx = 32'(code_i);
  assign hit_o    = code_idx < NUM_FREQ;

  for (genvar p = 0; p < NUM_PROF; p++) begin : g_prof
    assign prof_set[p] = div_lookup(p == 1, code_idx);
  end

  assign set_o = alt_i ? prof_set[1] : prof_set[0];

endmodule

// File: rtl/pll_wait_timer.sv
module pll_wait_timer #(
  parameter int unsigned LIMIT = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expired_o
);

  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == LIM);

  // R7
  tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && expired_o) |=> (expired_o || !$past(run_i)) );

endmodule

// File: rtl/pll_bus_master.sv
module pll_bus_master
  import pll_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start_i,
  input  logic              cmd_we_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  output logic              cmd_done_o,
  output logic [DATA_W-1:0] cmd_rdata_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic              req_we_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_wdata_o,
  input  logic              rsp_valid_i,
  input  logic [DATA_W-1:0] rsp_rdata_i
);

  typedef enum logic [1:0] {M_IDLE, M_REQ, M_RSP} mst_e;

  mst_e              st_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= M_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        M_IDLE: if (cmd_start_i) begin
          we_q    <= cmd_we_i;
          addr_q  <= cmd_addr_i;
          wdata_q <= cmd_wdata_i;
          st_q    <= M_REQ;
        end
        M_REQ: if (req_ready_i) st_q <= M_RSP;
        M_RSP: if (rsp_valid_i) begin
          rdata_q <= rsp_rdata_i;
          done_q  <= 1'b1;
          st_q    <= M_IDLE;
        end
        default: st_q <= M_IDLE;
      endcase
    end
  end

  assign req_valid_o = (st_q == M_REQ);
  assign req_we_o    = we_q;
  assign req_addr_o  = addr_q;
  assign req_wdata_o = wdata_q;
  assign cmd_done_o  = done_q;
  assign cmd_rdata_o = rdata_q;

  // R13
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o) &&
                                      $stable(req_we_o) && $stable(req_wdata_o)));

  // R13
  start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start_i |-> (st_q == M_IDLE));

endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq
  import pll_seq_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 2000,
  parameter int unsigned CODE_W         = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_req_i,
  input  logic              exit_req_i,
  input  logic              profile_i,
  input  logic [CODE_W-1:0] freq_code_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        err_code_o,
  output logic              bus_req_valid_o,
  input  logic              bus_req_ready_i,
  output logic              bus_req_we_o,
  output logic [7:0]        bus_req_addr_o,
  output logic [31:0]       bus_req_wdata_o,
  input  logic              bus_rsp_valid_i,
  input  logic [31:0]       bus_rsp_rdata_i
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_WAKE_RD, S_WAKE_WR, S_WAKE_POLL, S_STAT_RD, S_LOOKUP,
    S_FLD_RD, S_FLD_WR, S_GO_WR, S_LOCK_POLL, S_EXIT_RD, S_EXIT_WR,
    S_PD_POLL, S_FINISH
  } seq_e;

  seq_e              state_q;
  err_e              err_q;
  logic              alt_q;
  logic [CODE_W-1:0] code_q;
  logic [STEP_W-1:0] step_q;
  logic [DATA_W-1:0] rd_q;
  logic              pend_q;
  logic [ADDR_W-1:0] last_wr_addr_q;

  logic              needs_bus, cmd_start, cmd_we, cmd_done;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_wdata, cmd_rdata;
  logic              polling, tmr_expired;
  logic              st_lock, st_pd_both;
  div_set_t          div_set;
  logic              div_hit;

  pll_div_table #(.CODE_W(CODE_W)) u_table (
    .alt_i  (alt_q),
    .code_i (code_q),
    .set_o  (div_set),
    .hit_o  (div_hit)
  );

  assign polling = (state_q == S_WAKE_POLL) || (state_q == S_LOCK_POLL) ||
                   (state_q == S_PD_POLL);

  pll_wait_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (polling),
    .expired_o (tmr_expired)
  );

  // Bus command selection per state
  always_comb begin
    needs_bus = 1'b1;
    cmd_we    = 1'b0;
    cmd_addr  = ADDR_STAT;
    cmd_wdata = '0;
    case (state_q)
      S_WAKE_RD, S_EXIT_RD: cmd_addr = ADDR_CFG2;
      S_WAKE_WR: begin
        cmd_we    = 1'b1;
        cmd_addr  = ADDR_CFG2;
        cmd_wdata = rd_q & ~(DATA_W'(1) << CFG2_IDLE_BIT);
      end
      S_EXIT_WR: begin
        cmd_we    = 1'b1;
        cmd_addr  = ADDR_CFG2;
        cmd_wdata = rd_q | (DATA_W'(1) << CFG2_IDLE_BIT);
      end
      S_WAKE_POLL, S_STAT_RD, S_LOCK_POLL, S_PD_POLL: cmd_addr = ADDR_STAT;
      S_FLD_RD: cmd_addr = step_addr(step_q);
      S_FLD_WR: begin
        cmd_we    = 1'b1;
        cmd_addr  = step_addr(step_q);
        cmd_wdata = (rd_q & ~step_mask(step_q)) | step_value(step_q, div_set);
      end
      S_GO_WR: begin
        cmd_we    = 1'b1;
        cmd_addr  = ADDR_GO;
        cmd_wdata = DATA_W'(1);
      end
      default: needs_bus = 1'b0;
    endcase
  end

  assign cmd_start = needs_bus && !pend_q;

  pll_bus_master u_bus (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_start_i (cmd_start),
    .cmd_we_i    (cmd_we),
    .cmd_addr_i  (cmd_addr),
    .cmd_wdata_i (cmd_wdata),
    .cmd_done_o  (cmd_done),
    .cmd_rdata_o (cmd_rdata),
    .req_valid_o (bus_req_valid_o),
    .req_ready_i (bus_req_ready_i),
    .req_we_o    (bus_req_we_o),
    .req_addr_o  (bus_req_addr_o),
    .req_wdata_o (bus_req_wdata_o),
    .rsp_valid_i (bus_rsp_valid_i),
    .rsp_rdata_i (bus_rsp_rdata_i)
  );

  assign st_lock    = cmd_rdata[STAT_LOCK_BIT];
  assign st_pd_both = cmd_rdata[STAT_PDA_BIT] && cmd_rdata[STAT_PDB_BIT];

  // Sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      err_q   <= ERR_NONE;
      alt_q   <= 1'b0;
      code_q  <= '0;
      step_q  <= '0;
      rd_q    <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (cmd_start)     pend_q <= 1'b1;
      else if (cmd_done) pend_q <= 1'b0;

      case (state_q)
        S_IDLE: begin
          err_q <= ERR_NONE;
          if (init_req_i) begin
            alt_q   <= profile_i;
            code_q  <= freq_code_i;
            state_q <= S_WAKE_RD;
          end else if (exit_req_i) begin
            alt_q   <= profile_i;
            state_q <= profile_i ? S_FINISH : S_EXIT_RD;
          end
        end
        S_WAKE_RD: if (cmd_done) begin
          rd_q    <= cmd_rdata;
          state_q <= cmd_rdata[CFG2_IDLE_BIT] ? S_WAKE_WR : S_STAT_RD;
        end
        S_WAKE_WR: if (cmd_done) state_q <= S_WAKE_POLL;
        S_WAKE_POLL: if (cmd_done) begin
          if (st_lock) state_q <= S_STAT_RD;
          else if (tmr_expired) begin
            err_q   <= ERR_LOCK_TMO;
            state_q <= S_FINISH;
          end
        end
        S_STAT_RD: if (cmd_done) state_q <= st_lock ? S_FINISH : S_LOOKUP;
        S_LOOKUP: begin
          step_q <= '0;
          if (div_hit) state_q <= S_FLD_RD;
          else begin
            err_q   <= ERR_NO_ENTRY;
            state_q <= S_FINISH;
          end
        end
        S_FLD_RD: if (cmd_done) begin
          rd_q    <= cmd_rdata;
          state_q <= S_FLD_WR;
        end
        S_FLD_WR: if (cmd_done) begin
          if (step_q == LAST_STEP) state_q <= S_GO_WR;
          else begin
            step_q  <= step_q + 1'b1;
            state_q <= S_FLD_RD;
          end
        end
        S_GO_WR: if (cmd_done) state_q <= S_LOCK_POLL;
        S_LOCK_POLL: if (cmd_done) begin
          if (st_lock) state_q <= S_FINISH;
          else if (tmr_expired) begin
            err_q   <= ERR_LOCK_TMO;
            state_q <= S_FINISH;
          end
        end
        S_EXIT_RD: if (cmd_done) begin
          rd_q    <= cmd_rdata;
          state_q <= S_EXIT_WR;
        end
        S_EXIT_WR: if (cmd_done) state_q <= S_PD_POLL;
        S_PD_POLL: if (cmd_done) begin
          if (st_pd_both) state_q <= S_FINISH;
          else if (tmr_expired) begin
            err_q   <= ERR_PD_TMO;
            state_q <= S_FINISH;
          end
        end
        S_FINISH: state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = (state_q == S_FINISH);
  assign err_code_o = err_q;

  // Last accepted write address, kept for the ordering check below
  always_ff @(posedge clk) begin
    if (!rst_n) last_wr_addr_q <= '0;
    else if (bus_req_valid_o && bus_req_ready_i && bus_req_we_o) last_wr_addr_q <= bus_req_addr_o;
  end

  // R1
  bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !bus_req_valid_o);

  // R14
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  // R12
  busy_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

  // R6
  go_after_sd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid_o && bus_req_we_o && bus_req_addr_o == ADDR_GO) |-> (last_wr_addr_q == ADDR_CFG3));

  // R7
  tmo_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (err_code_o == ERR_LOCK_TMO || err_code_o == ERR_PD_TMO)) |-> $past(tmr_expired));

endmodule

// File: tb/tb_pll_bringup_seq.sv
module tb_pll_bringup_seq;

  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 80;
  localparam int DLY        = 12;
  localparam int WD_LIMIT   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_req = 1'b0, exit_req = 1'b0, profile = 1'b0;
  logic [2:0]  freq_code = '0;
  logic        busy_o, done_o;
  logic [1:0]  err_code_o;
  logic        bus_req_valid_o, bus_req_we_o;
  logic [7:0]  bus_req_addr_o;
  logic [31:0] bus_req_wdata_o;
  logic        bus_req_ready = 1'b0, bus_rsp_valid = 1'b0;
  logic [31:0] bus_rsp_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_bringup_seq #(.TIMEOUT_CYCLES(TMO), .CODE_W(3)) dut (
    .clk(clk), .rst_n(rst_n), .init_req_i(init_req), .exit_req_i(exit_req),
    .profile_i(profile), .freq_code_i(freq_code), .busy_o(busy_o), .done_o(done_o),
    .err_code_o(err_code_o), .bus_req_valid_o(bus_req_valid_o), .bus_req_ready_i(bus_req_ready),
    .bus_req_we_o(bus_req_we_o), .bus_req_addr_o(bus_req_addr_o), .bus_req_wdata_o(bus_req_wdata_o),
    .bus_rsp_valid_i(bus_rsp_valid), .bus_rsp_rdata_i(bus_rsp_rdata)
  );

  int n_cmp = 0, n_bad = 0;
  int cyc = 0, txn_cnt = 0, done_cnt = 0, go_cyc = 0;
  int lock_cnt = -1, pd_cnt = -1;
  bit go_locks, wake_locks, pd_works;
  logic [31:0] regs [0:15];
  logic [39:0] exp_wr [$];
  bit          hs_pend = 0;
  logic        hs_we;
  logic [7:0]  hs_addr;
  logic [31:0] hs_wdata;
  logic        prev_valid = 0, prev_ready = 0, prev_done = 0, prev_we = 0;
  logic [7:0]  prev_addr = '0;
  logic [31:0] prev_wdata = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Slave write handling and expected-order check (R5, R2, R6, R9)
  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    logic [39:0] e;
    logic [31:0] old;
    if (exp_wr.size() == 0) chk(0, "R5", "unexpected write", {a, d}, 0);
    else begin
      e = exp_wr.pop_front();
      chk(e == {a, d}, "R5", "write addr/data", {a, d}, e);
    end
    old = regs[a[5:2]];
    if (a != 8'h04) regs[a[5:2]] = d;
    if (a == 8'h10) begin
      if (old[0] && !d[0]) begin
        regs[1][16:15] = 2'b00;
        if (wake_locks) lock_cnt = DLY;
      end
      if (!old[0] && d[0]) begin
        regs[1][1] = 1'b0;
        lock_cnt = -1;
        if (pd_works) pd_cnt = DLY;
      end
    end
    if (a == 8'h08 && d == 32'd1) begin
      go_cyc = cyc;
      if (go_locks) lock_cnt = DLY;
    end
  endtask

  // Register slave and per-clock monitor
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > WD_LIMIT) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WD_LIMIT);
        summary();
        $finish;
      end
      if (!rst_n) begin
        bus_req_ready = 0; bus_rsp_valid = 0; hs_pend = 0; prev_valid = 0; prev_done = 0;
      end else begin
        // R1: no bus request outside a sequence
        chk(busy_o || !bus_req_valid_o, "R1", "valid while idle", bus_req_valid_o, 0);
        // R13: request held under back-pressure
        if (prev_valid && !prev_ready)
          chk(bus_req_valid_o && bus_req_addr_o == prev_addr && bus_req_we_o == prev_we &&
              bus_req_wdata_o == prev_wdata, "R13", "request changed while stalled",
              {bus_req_valid_o, bus_req_addr_o}, {1'b1, prev_addr});
        // R14: done is a one-cycle pulse ending busy
        if (prev_done) chk(!done_o && !busy_o, "R14", "done/busy after done", {done_o, busy_o}, 0);
        if (done_o) done_cnt++;
        prev_done = done_o;
        if (lock_cnt > 0) lock_cnt--;
        if (lock_cnt == 0) begin regs[1][1] = 1'b1; lock_cnt = -1; end
        if (pd_cnt > 0) pd_cnt--;
        if (pd_cnt == 0) begin regs[1][16:15] = 2'b11; pd_cnt = -1; end
        bus_rsp_valid = 0;
        if (hs_pend) begin
          txn_cnt++;
          if (hs_we) do_write(hs_addr, hs_wdata);
          else bus_rsp_rdata = regs[hs_addr[5:2]];
          bus_rsp_valid = 1;
          hs_pend = 0;
        end
        bus_req_ready = (cyc % 3) != 1;
        hs_pend  = bus_req_valid_o && bus_req_ready;
        hs_we    = bus_req_we_o;
        hs_addr  = bus_req_addr_o;
        hs_wdata = bus_req_wdata_o;
        prev_valid = bus_req_valid_o; prev_ready = bus_req_ready;
        prev_we = bus_req_we_o; prev_addr = bus_req_addr_o; prev_wdata = bus_req_wdata_o;
      end
    end
  end

  // Reference divider table (R4)
  task automatic ref_div(input bit alt, input int code,
                         output int m, output int n, output int sd, output int fr);
    int ma [6] = '{1000, 714, 625, 600, 461, 312};
    int mb [6] = '{1250, 3125, 1172, 1000, 1250, 3125};
    int nb [6] = '{5, 20, 8, 7, 12, 47};
    int sb [6] = '{20, 20, 20, 10, 20, 20};
    int fb [6] = '{0, 0, 65537, 0, 0, 92843};
    if (alt) begin m = ma[code]; n = 7; sd = 6; fr = 0; end
    else begin m = mb[code]; n = nb[code]; sd = sb[code]; fr = fb[code]; end
  endtask

  task automatic setup(input logic [31:0] c1, c2, c3, c4, stat,
                       input bit gl, input bit wl, input bit pw);
    for (int i = 0; i < 16; i++) regs[i] = 32'h0;
    regs[3] = c1; regs[4] = c2; regs[5] = c3; regs[8] = c4; regs[1] = stat;
    lock_cnt = -1; pd_cnt = -1;
    go_locks = gl; wake_locks = wl; pd_works = pw;
    exp_wr.delete();
  endtask

  // Expected field writes, then go (R4, R5, R6)
  task automatic exp_program(input bit alt, input int code);
    int m, n, sd, fr;
    logic [31:0] c1, c2, c3, c4;
    ref_div(alt, code, m, n, sd, fr);
    c1 = regs[3]; c2 = regs[4]; c3 = regs[5]; c4 = regs[8];
    c1 = (c1 & ~32'h1FE) | (32'(n) << 1);         exp_wr.push_back({8'h0C, c1});
    c2 = (c2 & ~32'hE) | (32'd4 << 1);            exp_wr.push_back({8'h10, c2});
    c1 = (c1 & ~32'h1FFE00) | (32'(m) << 9);      exp_wr.push_back({8'h0C, c1});
    c4 = (c4 & ~32'h3FFFF) | 32'(fr);             exp_wr.push_back({8'h20, c4});
    c3 = (c3 & ~32'h3FC00) | (32'(sd) << 10);     exp_wr.push_back({8'h14, c3});
    exp_wr.push_back({8'h08, 32'd1});
  endtask

  task automatic run_op(input bit is_init, input bit alt, input int code,
                        input int exp_err, input string req, output int done_at);
    int d0;
    bit seen;
    d0 = done_cnt; seen = 0; done_at = 0;
    @(negedge clk);
    profile = alt; freq_code = 3'(code);
    if (is_init) init_req = 1; else exit_req = 1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (i == 0) begin init_req = 0; exit_req = 0; end
      if (done_o) begin seen = 1; done_at = cyc; break; end
    end
    chk(seen, req, "done seen", seen, 1);
    chk(err_code_o == 2'(exp_err), req, "result code", err_code_o, exp_err);
    @(negedge clk);
    chk(exp_wr.size() == 0, req, "expected writes left", exp_wr.size(), 0);
    chk(done_cnt == d0 + 1, "R12", "done pulses per request", done_cnt - d0, 1);
  endtask

  initial begin
    int t, tx0;
    rst_n = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!busy_o && !done_o && !bus_req_valid_o, "R1", "reset outputs",
          {busy_o, done_o, bus_req_valid_o}, 0);
    end
    rst_n = 1;

    // R4 R5 R6: profile 0, code 0, all-ones neighbours preserved
    setup('1, 32'hFFFF_FFFE, '1, '1, 32'h0, 1, 1, 1);
    exp_program(0, 0);
    run_op(1, 0, 0, 0, "R6", t);

    // R4 R5: profile 0, code 5 with fractional part, mixed pattern
    setup(32'hA5A5_5A5A, 32'h5A5A_A5A4, 32'hA5A5_5A5A, 32'h5A5A_A5A5, 32'h0, 1, 1, 1);
    exp_program(0, 5);
    run_op(1, 0, 5, 0, "R4", t);

    // R4 R5: profile 1, code 3, zero registers
    setup('0, '0, '0, '0, 32'h0, 1, 1, 1);
    exp_program(1, 3);
    run_op(1, 1, 3, 0, "R4", t);

    // R2 R3: sleeping PLL is woken, relocks, no divider writes
    setup('0, 32'h0000_00C3, '0, '0, 32'h0, 1, 1, 1);
    exp_wr.push_back({8'h10, 32'h0000_00C2});
    run_op(1, 0, 2, 0, "R2", t);

    // R3: already locked, no writes at all
    setup('0, '0, '0, '0, 32'h0000_0002, 1, 1, 1);
    tx0 = txn_cnt;
    run_op(1, 0, 1, 0, "R3", t);
    chk(txn_cnt - tx0 == 2, "R3", "bus transfers", txn_cnt - tx0, 2);

    // R8: unsupported codes 6 and 7
    setup('0, '0, '0, '0, 32'h0, 1, 1, 1);
    run_op(1, 0, 6, 1, "R8", t);
    run_op(1, 1, 7, 1, "R8", t);

    // R2 R7: wake without lock times out
    setup('0, 32'h1, '0, '0, 32'h0, 1, 0, 1);
    exp_wr.push_back({8'h10, 32'h0});
    run_op(1, 0, 0, 2, "R2", t);

    // R7: lock never appears after go
    setup('0, '0, '0, '0, 32'h0, 0, 1, 1);
    exp_program(0, 4);
    run_op(1, 0, 4, 2, "R7", t);
    chk(t - go_cyc >= TMO && t - go_cyc <= TMO + 20, "R7", "timeout latency",
        t - go_cyc, TMO);

    // R9: stop request in profile 0
    setup('0, 32'h0000_0010, '0, '0, 32'h0000_0002, 1, 1, 1);
    exp_wr.push_back({8'h10, 32'h0000_0011});
    run_op(0, 0, 0, 0, "R9", t);
    chk(regs[1][16:15] == 2'b11 && regs[1][1] == 1'b0, "R9", "status after stop",
        regs[1], 32'h18000);

    // R10: power-down never completes
    setup('0, '0, '0, '0, 32'h0000_0002, 1, 1, 0);
    exp_wr.push_back({8'h10, 32'h1});
    run_op(0, 0, 0, 3, "R10", t);

    // R11: stop request in profile 1 touches nothing
    setup('0, '0, '0, '0, 32'h0000_0002, 1, 1, 1);
    tx0 = txn_cnt;
    run_op(0, 1, 0, 0, "R11", t);
    chk(txn_cnt == tx0, "R11", "bus transfers", txn_cnt - tx0, 0);

    // R12: requests while busy are dropped
    setup('0, '0, '0, '0, 32'h0, 1, 1, 1);
    exp_program(0, 3);
    fork
      run_op(1, 0, 3, 0, "R12", t);
      begin
        repeat (20) @(negedge clk);
        exit_req = 1; init_req = 1;
        @(negedge clk);
        exit_req = 0; init_req = 0;
      end
    join
    tx0 = txn_cnt;
    repeat (30) @(negedge clk);
    chk(txn_cnt == tx0 && !busy_o, "R12", "traffic after sequence", txn_cnt - tx0, 0);
    chk(regs[4][0] == 1'b0, "R12", "sleep bit untouched", regs[4][0], 0);

    summary();
    $finish;
  end

endmodule